// File: doc/BRIEF.md
# Decode-Stage Stall Generator

This block decides, every cycle, whether the instruction sitting in the fetch/decode register of a five-stage pipeline may move on. The pipeline resolves branch comparisons in decode, so a branch needs its compare operands earlier than an ordinary ALU instruction. The block compares the two source register numbers of the decoding instruction with the destination register numbers of the two older instructions in the decode/execute and execute/memory registers. It uses each producer's write and memory-read flags to tell a load from an ALU result.

When a hazard is found, the block holds the program counter and the fetch/decode register and asks the pipeline to load a bubble (all control fields zero) into decode/execute. The block is purely combinational. The number of bubbles follows from the way a stalled instruction meets its producer again one stage further on. An ALU instruction that uses a load result waits one cycle. A branch waits one cycle behind an ALU producer or a load two slots ahead, and two cycles behind a load just ahead. A branch does not wait when the ALU producer is two or more slots ahead, because forwarding covers that case.

Top module: `hazard_stall_unit`

## Requirements
- R1: A non-branch instruction whose first source equals the nonzero destination of a load (memory-read flag 1) in decode/execute causes a stall.
- R2: A non-branch instruction whose second source equals the nonzero destination of a load in decode/execute causes a stall.
- R3: A non-branch instruction never stalls on an ALU producer in decode/execute, or on any producer in execute/memory.
- R4: A branch whose source matches the nonzero destination of a decode/execute instruction that writes a register or reads memory stalls; a producer with both flags 0 does not stall it.
- R5: A branch whose source matches the nonzero destination of a load in execute/memory stalls.
- R6: A branch never stalls on an ALU producer in execute/memory.
- R7: A producer whose destination is register 0 never causes a stall.
- R8: With no hazard, the program-counter and fetch/decode write enables are 1 and the bubble request is 0. During a stall, both enables are 0 and the bubble request is 1.
- R9: In a running pipeline, the bubble counts are: load then dependent ALU, 1; load then dependent branch, 2; load, unrelated, branch, 1; ALU then dependent branch, 1; ALU, unrelated, branch, 0; load, unrelated, ALU consumer, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs_i | input | 5 | First source register of the decoding instruction |
| ifid_rt_i | input | 5 | Second source register of the decoding instruction |
| ifid_branch_i | input | 1 | Decoding instruction is a branch compared in decode |
| idex_dst_i | input | 5 | Destination register of the decode/execute instruction |
| idex_regwrite_i | input | 1 | Decode/execute instruction writes a register |
| idex_memread_i | input | 1 | Decode/execute instruction is a load |
| exmem_dst_i | input | 5 | Destination register of the execute/memory instruction |
| exmem_regwrite_i | input | 1 | Execute/memory instruction writes a register |
| exmem_memread_i | input | 1 | Execute/memory instruction is a load |
| pc_we_o | output | 1 | Program counter may update |
| ifid_we_o | output | 1 | Fetch/decode register may update |
| idex_bubble_o | output | 1 | Zero the control fields entering decode/execute |

## Verification
The hardest case to reach is the second bubble behind a load that feeds a branch. The first stall cannot show this, because it comes from the decode/execute slot alone. The second stall appears only after the load has moved into execute/memory and a bubble has taken its old place. A single vector cannot set that up. The bench therefore runs a small pipeline model that is driven by the block's own enables. It feeds in short instruction sequences and counts the cycles in which the consumer stays in decode.

// File: rtl/hzu_pkg.sv
// Shared types for the decode-stage stall generator.
// Assumes a producer that reads memory is a load whether or not its write flag is set.
package hzu_pkg;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,   // writes nothing: store, branch, bubble
        PK_ALU  = 2'd1,   // result ready at end of execute
        PK_LOAD = 2'd2    // result ready at end of memory
    } prod_kind_t;

    // Turn a producer's control flags into its kind.
    function automatic prod_kind_t classify(input logic regwrite, input logic memread);
        if (memread)       return PK_LOAD;
        else if (regwrite) return PK_ALU;
        else               return PK_NONE;
    endfunction

endpackage

// File: rtl/hzu_src_match.sv
// Compares one producer destination with both consumer sources.
// Assumes register 0 is hard-wired, so a zero destination never matches.
module hzu_src_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] dst_i,
    input  logic [AW-1:0] src_a_i,
    input  logic [AW-1:0] src_b_i,
    output logic          hit_o
);

    logic dst_live;

    // Match either source against a nonzero destination.
    always_comb begin
        dst_live = (dst_i != '0);
        hit_o    = dst_live && ((dst_i == src_a_i) || (dst_i == src_b_i));
    end

    // R7 guard: a zero destination must not report a match.
    always_comb begin
        if (dst_i == '0) begin
            a_r7_zero_dst_no_hit: assert (!hit_o)
                else $error("a_r7_zero_dst_no_hit");
        end
    end

endmodule

// File: rtl/hzu_stall_decide.sv
// Combines the producer kinds and matches into one stall decision.
// Assumes near = decode/execute slot, far = execute/memory slot.
module hzu_stall_decide
    import hzu_pkg::*;
(
    input  prod_kind_t near_kind_i,
    input  logic       near_hit_i,
    input  prod_kind_t far_kind_i,
    input  logic       far_hit_i,
    input  logic       is_branch_i,
    output logic       stall_o
);

    logic load_use;
    logic br_near;
    logic br_far;

    // Classify the three stalling situations.
    always_comb begin
        load_use = (near_kind_i == PK_LOAD) && near_hit_i;
        br_near  = is_branch_i && (near_kind_i != PK_NONE) && near_hit_i;
        br_far   = is_branch_i && (far_kind_i == PK_LOAD) && far_hit_i;
        stall_o  = load_use || br_near || br_far;
    end

    // R3 and R6 guards: forwarding-covered pairings never stall.
    always_comb begin
        if (!is_branch_i && (near_kind_i != PK_LOAD)) begin
            a_r3_alu_consumer_no_stall: assert (!stall_o)
                else $error("a_r3_alu_consumer_no_stall");
        end
        if (is_branch_i && !near_hit_i && (far_kind_i == PK_ALU)) begin
            a_r6_far_alu_no_stall: assert (!stall_o)
                else $error("a_r6_far_alu_no_stall");
        end
    end

endmodule

// File: rtl/hazard_stall_unit.sv
// Decode-stage stall generator for a pipeline that compares branches in decode.
// Assumes the pipeline zeroes decode/execute control when idex_bubble_o is 1
// and holds PC and fetch/decode when the write enables are 0.
module hazard_stall_unit #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ifid_rs_i,
    input  logic [AW-1:0] ifid_rt_i,
    input  logic          ifid_branch_i,
    input  logic [AW-1:0] idex_dst_i,
    input  logic          idex_regwrite_i,
    input  logic          idex_memread_i,
    input  logic [AW-1:0] exmem_dst_i,
    input  logic          exmem_regwrite_i,
    input  logic          exmem_memread_i,
    output logic          pc_we_o,
    output logic          ifid_we_o,
    output logic          idex_bubble_o
);
    import hzu_pkg::*;

    localparam int NSLOT = 2;   // 0: decode/execute, 1: execute/memory

    logic [AW-1:0] slot_dst [NSLOT];
    logic          slot_rw  [NSLOT];
    logic          slot_mr  [NSLOT];
    prod_kind_t    slot_kind[NSLOT];
    logic          slot_hit [NSLOT];
    logic          stall;

    // Gather producer slots into arrays.
    always_comb begin
        slot_dst[0] = idex_dst_i;
        slot_rw[0]  = idex_regwrite_i;
        slot_mr[0]  = idex_memread_i;
        slot_dst[1] = exmem_dst_i;
        slot_rw[1]  = exmem_regwrite_i;
        slot_mr[1]  = exmem_memread_i;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        hzu_src_match #(.AW(AW)) u_match (
            .dst_i   (slot_dst[g]),
            .src_a_i (ifid_rs_i),
            .src_b_i (ifid_rt_i),
            .hit_o   (slot_hit[g])
        );
        // Classify this slot's producer.
        always_comb slot_kind[g] = classify(slot_rw[g], slot_mr[g]);
    end

    hzu_stall_decide u_decide (
        .near_kind_i (slot_kind[0]),
        .near_hit_i  (slot_hit[0]),
        .far_kind_i  (slot_kind[1]),
        .far_hit_i   (slot_hit[1]),
        .is_branch_i (ifid_branch_i),
        .stall_o     (stall)
    );

    // Drive the three pipeline controls from one decision.
    always_comb begin
        pc_we_o       = !stall;
        ifid_we_o     = !stall;
        idex_bubble_o = stall;
    end

    // R1/R2 and R5 guards stated on the ports.
    always_comb begin
        if (idex_memread_i && (idex_dst_i != '0) &&
            ((idex_dst_i == ifid_rs_i) || (idex_dst_i == ifid_rt_i))) begin
            a_r1_r2_load_use_holds: assert (!pc_we_o && !ifid_we_o && idex_bubble_o)
                else $error("a_r1_r2_load_use_holds");
        end
        if (ifid_branch_i && exmem_memread_i && (exmem_dst_i != '0) &&
            ((exmem_dst_i == ifid_rs_i) || (exmem_dst_i == ifid_rt_i))) begin
            a_r5_branch_far_load: assert (idex_bubble_o)
                else $error("a_r5_branch_far_load");
        end
    end

endmodule

// File: tb/tb_hazard_stall_unit.sv
module tb_hazard_stall_unit;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [4:0] rs, rt, idst, edst;
    logic br, irw, imr, erw, emr;
    logic pc_we, ifid_we, bubble;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    hazard_stall_unit dut (
        .ifid_rs_i(rs), .ifid_rt_i(rt), .ifid_branch_i(br),
        .idex_dst_i(idst), .idex_regwrite_i(irw), .idex_memread_i(imr),
        .exmem_dst_i(edst), .exmem_regwrite_i(erw), .exmem_memread_i(emr),
        .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_bubble_o(bubble)
    );

    // Vector: br, rs, rt, idst, irw, imr, edst, erw, emr, expected stall, req
    localparam int NV = 12;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0,5'd3,5'd4, 5'd3,1'b1,1'b1, 5'd0,1'b0,1'b0, 1'b1, 4'd1}, // R1
        {1'b0,5'd5,5'd3, 5'd3,1'b1,1'b1, 5'd0,1'b0,1'b0, 1'b1, 4'd2}, // R2
        {1'b0,5'd3,5'd4, 5'd3,1'b1,1'b0, 5'd0,1'b0,1'b0, 1'b0, 4'd3}, // R3
        {1'b0,5'd3,5'd4, 5'd9,1'b1,1'b1, 5'd3,1'b1,1'b1, 1'b0, 4'd3}, // R3
        {1'b1,5'd3,5'd4, 5'd4,1'b1,1'b0, 5'd0,1'b0,1'b0, 1'b1, 4'd4}, // R4
        {1'b1,5'd3,5'd4, 5'd3,1'b1,1'b1, 5'd0,1'b0,1'b0, 1'b1, 4'd4}, // R4
        {1'b1,5'd3,5'd4, 5'd3,1'b0,1'b0, 5'd0,1'b0,1'b0, 1'b0, 4'd4}, // R4
        {1'b1,5'd6,5'd3, 5'd0,1'b0,1'b0, 5'd3,1'b1,1'b1, 1'b1, 4'd5}, // R5
        {1'b1,5'd6,5'd3, 5'd0,1'b0,1'b0, 5'd3,1'b1,1'b0, 1'b0, 4'd6}, // R6
        {1'b1,5'd0,5'd0, 5'd0,1'b1,1'b1, 5'd0,1'b1,1'b1, 1'b0, 4'd7}, // R7
        {1'b0,5'd0,5'd2, 5'd0,1'b1,1'b1, 5'd0,1'b0,1'b0, 1'b0, 4'd7}, // R7
        {1'b1,5'd1,5'd2, 5'd7,1'b1,1'b1, 5'd8,1'b1,1'b1, 1'b0, 4'd8}  // R8
    };

    task automatic check(input logic got, input logic exp, input int req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic [29:0] v);
        {br, rs, rt, idst, irw, imr, edst, erw, emr} = v[29:5];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Instruction for the pipeline model: branch, load, write, dst, rs, rt
    typedef struct packed {
        logic       br;
        logic       ld;
        logic       wr;
        logic [4:0] dst;
        logic [4:0] rs;
        logic [4:0] rt;
    } ins_t;

    localparam ins_t NOP = '0;

    // Runs prod, nfill NOPs, cons in a pipeline model steered by the DUT; R9.
    task automatic run_seq(input ins_t prod, input int nfill, input ins_t cons,
                           input int exp_bubbles, input string name);
        ins_t prog [6];
        ins_t ifid, idex, exmem;
        int pc = 0;
        int ifid_idx = -1;
        int cons_idx = nfill + 1;
        int bubbles = 0;
        for (int i = 0; i < 6; i++) prog[i] = NOP;
        prog[0] = prod;
        prog[cons_idx] = cons;
        ifid = NOP; idex = NOP; exmem = NOP;
        for (int cyc = 0; cyc < 20; cyc++) begin
            @(posedge clk);
            #1;
            br = ifid.br; rs = ifid.rs; rt = ifid.rt;
            idst = idex.dst; irw = idex.wr; imr = idex.ld;
            edst = exmem.dst; erw = exmem.wr; emr = exmem.ld;
            @(negedge clk);
            if (ifid_idx == cons_idx && bubble) bubbles++;
            exmem = idex;
            if (!pc_we) begin
                idex = NOP;
            end else begin
                if (ifid_idx == cons_idx) break;
                idex = ifid;
                ifid = prog[pc];
                ifid_idx = pc;
                pc++;
            end
        end
        n_checks++;
        if (bubbles != exp_bubbles) begin
            n_fail++;
            $display("FAIL R9 %s: actual %0d bubbles expected %0d", name, bubbles, exp_bubbles);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Idle inputs: no hazard, all enables open (R8).
        drive('0);
        @(negedge clk);
        check(pc_we, 1'b1, 8, "idle pc_we");
        check(bubble, 1'b0, 8, "idle bubble");

        // Vector table walk, checking all three outputs (R1..R8).
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            #1 drive(VEC[i]);
            @(negedge clk);
            check(pc_we,   ~VEC[i][4], int'(VEC[i][3:0]), $sformatf("vec %0d pc_we", i));
            check(ifid_we, ~VEC[i][4], int'(VEC[i][3:0]), $sformatf("vec %0d ifid_we", i));
            check(bubble,   VEC[i][4], int'(VEC[i][3:0]), $sformatf("vec %0d bubble", i));
        end

        // R9: exact bubble counts per producer/consumer pairing.
        run_seq('{1'b0,1'b1,1'b1,5'd3,5'd0,5'd0}, 0, '{1'b0,1'b0,1'b1,5'd9,5'd3,5'd4}, 1, "load->alu");
        run_seq('{1'b0,1'b1,1'b1,5'd3,5'd0,5'd0}, 0, '{1'b1,1'b0,1'b0,5'd0,5'd3,5'd4}, 2, "load->branch");
        run_seq('{1'b0,1'b1,1'b1,5'd3,5'd0,5'd0}, 1, '{1'b1,1'b0,1'b0,5'd0,5'd4,5'd3}, 1, "load,x->branch");
        run_seq('{1'b0,1'b0,1'b1,5'd4,5'd1,5'd2}, 0, '{1'b1,1'b0,1'b0,5'd0,5'd3,5'd4}, 1, "alu->branch");
        run_seq('{1'b0,1'b0,1'b1,5'd4,5'd1,5'd2}, 1, '{1'b1,1'b0,1'b0,5'd0,5'd3,5'd4}, 0, "alu,x->branch");
        run_seq('{1'b0,1'b0,1'b1,5'd4,5'd1,5'd2}, 2, '{1'b1,1'b0,1'b0,5'd0,5'd3,5'd4}, 0, "alu,x,x->branch");
        run_seq('{1'b0,1'b1,1'b1,5'd3,5'd0,5'd0}, 1, '{1'b0,1'b0,1'b1,5'd9,5'd3,5'd4}, 0, "load,x->alu");
        run_seq('{1'b0,1'b1,1'b1,5'd0,5'd0,5'd0}, 0, '{1'b1,1'b0,1'b0,5'd0,5'd0,5'd0}, 0, "load r0->branch R7");

        finish_run();
    end
endmodule